// File: doc/BRIEF.md
# Two-Layer Stub Coincidence Finder

This block pairs clusters seen on two stacked silicon sensor layers, called the bottom flow and the top flow. Each cycle it receives up to six clusters per layer. Each cluster has a position in half-strip units, a width in strips and a valid bit. Clusters wider than a programmable limit are dropped on both layers. For every surviving bottom cluster the block then searches the surviving top clusters for one whose position, minus the bottom position, lies inside a signed window with programmable bounds. A narrow window keeps only tracks that bend little in the magnetic field, which means high transverse momentum.

Each matching bottom cluster yields one stub, which carries the bottom position and the signed offset. Up to four stubs are presented each cycle, one register stage after the clusters arrive. A full flag from the downstream FIFO suppresses the stubs. A saturating counter records how many stubs were discarded that way.

Top module: `stub_finder`

## Requirements
- R1: A stub produced from the clusters presented at a rising edge appears on the outputs right after that edge and stays there for one cycle.
- R2: The offset is top position minus bottom position, as a signed value one bit wider than a position. A pair matches only when cfg_omin <= offset <= cfg_omax, with both bounds inclusive and two's-complement.
- R3: A cluster on either layer whose width is greater than cfg_wmax never takes part in a stub. A width equal to cfg_wmax is accepted.
- R4: A cluster whose valid bit is low never takes part in a stub, whatever its position and width.
- R5: When several top clusters match one bottom cluster, the stub takes the offset of the matching top cluster with the lowest index.
- R6: Each bottom cluster gives at most one stub. Stubs fill the slots from slot 0 upward, in ascending bottom index, so the valid bits are always contiguous from bit 0. When more than four bottom clusters match, the four with the lowest indices are kept and the rest are dropped.
- R7: When fifo_full is high at an edge, every stub valid output is low after that edge.
- R8: When fifo_full is high at an edge, ovf_cnt grows by the number of stubs that edge would have produced (at most four). It saturates at its maximum value and does not change while fifo_full is low.
- R9: During reset all stub valid outputs are low and ovf_cnt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bot_vld | input | 6 | Valid bits of the bottom-layer clusters |
| bot_pos | input | 48 | Bottom positions, cluster i in bits [8i+7:8i] |
| bot_wid | input | 18 | Bottom widths, cluster i in bits [3i+2:3i] |
| top_vld | input | 6 | Valid bits of the top-layer clusters |
| top_pos | input | 48 | Top positions, same packing as bot_pos |
| top_wid | input | 18 | Top widths, same packing as bot_wid |
| cfg_wmax | input | 3 | Largest accepted cluster width |
| cfg_omin | input | 9 | Signed lower bound of the offset window |
| cfg_omax | input | 9 | Signed upper bound of the offset window |
| fifo_full | input | 1 | Downstream FIFO full; suppresses stubs |
| stub_vld | output | 4 | Valid bit of each stub slot |
| stub_bpos | output | 32 | Bottom position of each stub, slot k in bits [8k+7:8k] |
| stub_off | output | 36 | Signed offset of each stub, slot k in bits [9k+8:9k] |
| ovf_cnt | output | 16 | Saturating count of stubs discarded while full |

## Verification
A wrong pairing choice inside the block shows up as a wrong offset in the affected slot. The cases are a top search that stops at the wrong index, a window compare that is off by one at a bound, or a width cut that tests the wrong layer. The error appears in the cycle right after the offending clusters. A faulty compaction state shows up in that same cycle as a gap in the stub valid bits, or as a dropped low-index stub. A faulty overflow counter appears as a wrong ovf_cnt after the first full cycle, and the error persists because the count only accumulates. Directed boundary patterns are mixed with random traffic, and every output cycle is compared against a reference computed from the requirements.

// File: rtl/stub_pkg.sv
package stub_pkg;
  localparam int unsigned POS_W_DEF = 8;
  localparam int unsigned WID_W_DEF = 3;
  localparam int unsigned N_CL_DEF  = 6;
  localparam int unsigned N_OUT_DEF = 4;
  localparam int unsigned CNT_W_DEF = 16;

  function automatic logic in_window(input logic signed [31:0] off,
                                     input logic signed [31:0] lo,
                                     input logic signed [31:0] hi);
    return (off >= lo) && (off <= hi);
  endfunction
endpackage

// File: rtl/stub_pair_match.sv
module stub_pair_match
  import stub_pkg::*;
#(
  parameter int unsigned N_TOP = 6,
  parameter int unsigned POS_W = 8,
  localparam int unsigned OFF_W = POS_W + 1
) (
  input  logic                     b_ok,
  input  logic [POS_W-1:0]         b_pos,
  input  logic [N_TOP-1:0]         t_ok,
  input  logic [N_TOP*POS_W-1:0]   t_pos,
  input  logic [OFF_W-1:0]         omin,
  input  logic [OFF_W-1:0]         omax,
  output logic                     hit,
  output logic [OFF_W-1:0]         off
);
  logic [N_TOP-1:0]         cand;
  logic [N_TOP*OFF_W-1:0]   diff;

  for (genvar j = 0; j < N_TOP; j++) begin : g_top
    assign diff[j*OFF_W +: OFF_W] = {1'b0, t_pos[j*POS_W +: POS_W]} - {1'b0, b_pos};
    assign cand[j] = b_ok && t_ok[j] &&
                     in_window(32'($signed(diff[j*OFF_W +: OFF_W])),
                               32'($signed(omin)), 32'($signed(omax)));
  end

  always_comb begin
    hit = 1'b0;
    off = '0;
    for (int j = N_TOP - 1; j >= 0; j--) begin
      if (cand[j]) begin
        hit = 1'b1;
        off = diff[j*OFF_W +: OFF_W];
      end
    end
  end
endmodule

// File: rtl/stub_select.sv
module stub_select #(
  parameter int unsigned N_BOT = 6,
  parameter int unsigned N_OUT = 4,
  parameter int unsigned POS_W = 8,
  localparam int unsigned OFF_W = POS_W + 1,
  localparam int unsigned NS_W  = $clog2(N_OUT + 1)
) (
  input  logic [N_BOT-1:0]        hit,
  input  logic [N_BOT*POS_W-1:0]  b_pos,
  input  logic [N_BOT*OFF_W-1:0]  b_off,
  output logic [N_OUT-1:0]        o_vld,
  output logic [N_OUT*POS_W-1:0]  o_pos,
  output logic [N_OUT*OFF_W-1:0]  o_off,
  output logic [NS_W-1:0]         n_sel
);
  always_comb begin
    int k;
    k     = 0;
    o_vld = '0;
    o_pos = '0;
    o_off = '0;
    for (int i = 0; i < N_BOT; i++) begin
      if (hit[i] && (k < N_OUT)) begin
        o_vld[k]                = 1'b1;
        o_pos[k*POS_W +: POS_W] = b_pos[i*POS_W +: POS_W];
        o_off[k*OFF_W +: OFF_W] = b_off[i*OFF_W +: OFF_W];
        k++;
      end
    end
    n_sel = NS_W'(k);
  end
endmodule

// File: rtl/stub_finder.sv
module stub_finder
  import stub_pkg::*;
#(
  parameter int unsigned N_CL  = N_CL_DEF,
  parameter int unsigned N_OUT = N_OUT_DEF,
  parameter int unsigned POS_W = POS_W_DEF,
  parameter int unsigned WID_W = WID_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF,
  localparam int unsigned OFF_W = POS_W + 1,
  localparam int unsigned NS_W  = $clog2(N_OUT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CL-1:0]         bot_vld,
  input  logic [N_CL*POS_W-1:0]   bot_pos,
  input  logic [N_CL*WID_W-1:0]   bot_wid,
  input  logic [N_CL-1:0]         top_vld,
  input  logic [N_CL*POS_W-1:0]   top_pos,
  input  logic [N_CL*WID_W-1:0]   top_wid,
  input  logic [WID_W-1:0]        cfg_wmax,
  input  logic [OFF_W-1:0]        cfg_omin,
  input  logic [OFF_W-1:0]        cfg_omax,
  input  logic                    fifo_full,
  output logic [N_OUT-1:0]        stub_vld,
  output logic [N_OUT*POS_W-1:0]  stub_bpos,
  output logic [N_OUT*OFF_W-1:0]  stub_off,
  output logic [CNT_W-1:0]        ovf_cnt
);
  logic [N_CL-1:0]         b_ok, t_ok, hit;
  logic [N_CL*OFF_W-1:0]   m_off;
  logic [N_OUT-1:0]        s_vld;
  logic [N_OUT*POS_W-1:0]  s_pos;
  logic [N_OUT*OFF_W-1:0]  s_off;
  logic [NS_W-1:0]         n_sel;

  for (genvar i = 0; i < N_CL; i++) begin : g_cut
    assign b_ok[i] = bot_vld[i] && (bot_wid[i*WID_W +: WID_W] <= cfg_wmax);
    assign t_ok[i] = top_vld[i] && (top_wid[i*WID_W +: WID_W] <= cfg_wmax);
  end

  for (genvar i = 0; i < N_CL; i++) begin : g_bot
    stub_pair_match #(.N_TOP(N_CL), .POS_W(POS_W)) u_match (
      .b_ok (b_ok[i]),
      .b_pos(bot_pos[i*POS_W +: POS_W]),
      .t_ok (t_ok),
      .t_pos(top_pos),
      .omin (cfg_omin),
      .omax (cfg_omax),
      .hit  (hit[i]),
      .off  (m_off[i*OFF_W +: OFF_W])
    );
  end

  stub_select #(.N_BOT(N_CL), .N_OUT(N_OUT), .POS_W(POS_W)) u_sel (
    .hit  (hit),
    .b_pos(bot_pos),
    .b_off(m_off),
    .o_vld(s_vld),
    .o_pos(s_pos),
    .o_off(s_off),
    .n_sel(n_sel)
  );

  // next-state logic
  logic [N_OUT-1:0] vld_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W:0]   cnt_sum;
  logic             cnt_en;

  always_comb begin
    vld_nxt = fifo_full ? '0 : s_vld;
    cnt_en  = fifo_full;
    cnt_sum = {1'b0, ovf_cnt} + (CNT_W+1)'(n_sel);
    cnt_nxt = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stub_vld  <= '0;
      stub_bpos <= '0;
      stub_off  <= '0;
      ovf_cnt   <= '0;
    end else begin
      stub_vld  <= vld_nxt;
      stub_bpos <= s_pos;
      stub_off  <= s_off;
      if (cnt_en) ovf_cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/stub_finder_chk.sv
module stub_finder_chk #(
  parameter int unsigned N_CL  = 6,
  parameter int unsigned N_OUT = 4,
  parameter int unsigned POS_W = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned OFF_W = POS_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CL-1:0]         bot_vld,
  input logic [OFF_W-1:0]        cfg_omin,
  input logic [OFF_W-1:0]        cfg_omax,
  input logic                    fifo_full,
  input logic [N_OUT-1:0]        stub_vld,
  input logic [N_OUT*OFF_W-1:0]  stub_off,
  input logic [CNT_W-1:0]        ovf_cnt
);
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> (stub_vld == '0));

  a_r4_no_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (bot_vld == '0) |=> (stub_vld == '0));

  a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((stub_vld & (stub_vld + 1'b1)) == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_full |=> $stable(ovf_cnt));

  a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> (ovf_cnt >= $past(ovf_cnt)));

  for (genvar k = 0; k < N_OUT; k++) begin : g_slot
    a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
      stub_vld[k] |->
        ($signed(stub_off[k*OFF_W +: OFF_W]) >= $signed($past(cfg_omin))) &&
        ($signed(stub_off[k*OFF_W +: OFF_W]) <= $signed($past(cfg_omax))));
  end
endmodule

bind stub_finder stub_finder_chk #(
  .N_CL(N_CL), .N_OUT(N_OUT), .POS_W(POS_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bot_vld(bot_vld), .cfg_omin(cfg_omin),
  .cfg_omax(cfg_omax), .fifo_full(fifo_full), .stub_vld(stub_vld),
  .stub_off(stub_off), .ovf_cnt(ovf_cnt)
);

// File: tb/stub_finder_test.sv
module stub_finder_test;
  localparam int CLK_P = 10;
  localparam int CW    = 6;

  logic        clk, rst_n;
  logic [5:0]  bot_vld, top_vld;
  logic [47:0] bot_pos, top_pos;
  logic [17:0] bot_wid, top_wid;
  logic [2:0]  cfg_wmax;
  logic [8:0]  cfg_omin, cfg_omax;
  logic        fifo_full;
  logic [3:0]  stub_vld;
  logic [31:0] stub_bpos;
  logic [35:0] stub_off;
  logic [CW-1:0] ovf_cnt;

  stub_finder #(.CNT_W(CW)) uut (.*);

  typedef struct {
    logic [3:0] vld;
    int         bpos [4];
    int         off  [4];
    int         cnt;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   m_cnt  = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic clear_in();
    bot_vld = '0; top_vld = '0; bot_pos = '0; top_pos = '0;
    bot_wid = '0; top_wid = '0; fifo_full = 1'b0;
  endtask

  task automatic set_b(input int i, input int pos, input int wid);
    bot_vld[i] = 1'b1; bot_pos[i*8 +: 8] = 8'(pos); bot_wid[i*3 +: 3] = 3'(wid);
  endtask

  task automatic set_t(input int i, input int pos, input int wid);
    top_vld[i] = 1'b1; top_pos[i*8 +: 8] = 8'(pos); top_wid[i*3 +: 3] = 3'(wid);
  endtask

  // reference from the requirements; pushes one expected item per cycle
  task automatic step(input string tag);
    exp_t e;
    int n, lo, hi, wm;
    lo = int'($signed(cfg_omin)); hi = int'($signed(cfg_omax)); wm = int'(cfg_wmax);
    e.vld = '0; e.tag = tag; n = 0;
    for (int k = 0; k < 4; k++) begin e.bpos[k] = 0; e.off[k] = 0; end
    for (int i = 0; i < 6; i++) begin
      int bp, found, fo;
      bp = int'(bot_pos[i*8 +: 8]); found = 0; fo = 0;
      if (bot_vld[i] && int'(bot_wid[i*3 +: 3]) <= wm) begin
        for (int j = 0; j < 6; j++) begin
          int d;
          d = int'(top_pos[j*8 +: 8]) - bp;
          if (!found && top_vld[j] && int'(top_wid[j*3 +: 3]) <= wm && d >= lo && d <= hi) begin
            found = 1; fo = d;
          end
        end
      end
      if (found && n < 4) begin
        e.vld[n] = 1'b1; e.bpos[n] = bp; e.off[n] = fo; n++;
      end
    end
    if (fifo_full) begin
      e.vld = '0;
      m_cnt = (m_cnt + n > (1 << CW) - 1) ? (1 << CW) - 1 : m_cnt + n;
    end
    e.cnt = m_cnt;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n && q.size() > 0) begin
        exp_t e;
        logic bad;
        e = q.pop_front();
        bad = 1'b0;
        checks++;
        if (stub_vld !== e.vld) bad = 1'b1;
        for (int k = 0; k < 4; k++)
          if (e.vld[k] && (int'(stub_bpos[k*8 +: 8]) != e.bpos[k] ||
                           int'($signed(stub_off[k*9 +: 9])) != e.off[k])) bad = 1'b1;
        if (int'(ovf_cnt) != e.cnt) bad = 1'b1;
        if (bad) begin
          errors++;
          $display("FAIL %s vld=%b/%b bpos=%h off=%h cnt=%0d exp vld=%b bpos0=%0d off0=%0d bpos1=%0d off1=%0d cnt=%0d",
                   e.tag, stub_vld, e.vld, stub_bpos, stub_off, ovf_cnt,
                   e.vld, e.bpos[0], e.off[0], e.bpos[1], e.off[1], e.cnt);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_in();
    cfg_wmax = 3'd3; cfg_omin = -9'sd4; cfg_omax = 9'sd3;
    repeat (3) @(negedge clk);
    checks++;
    if (stub_vld !== 4'b0 || ovf_cnt !== '0) begin
      errors++;
      $display("FAIL R9 reset vld=%b cnt=%0d exp vld=0000 cnt=0", stub_vld, ovf_cnt);
    end
    rst_n = 1'b1;

    // R1 R2: single exact match, then idle shows one-cycle stub
    clear_in(); set_b(0, 50, 1); set_t(0, 50, 1); step("R1");
    clear_in(); step("R1");
    // R2 window bounds
    clear_in(); set_b(0, 20, 1); set_t(0, 23, 1); step("R2");
    clear_in(); set_b(0, 20, 1); set_t(0, 24, 1); step("R2");
    clear_in(); set_b(0, 20, 1); set_t(0, 16, 1); step("R2");
    clear_in(); set_b(0, 20, 1); set_t(0, 15, 1); step("R2");
    clear_in(); set_b(0, 2, 1);  set_t(0, 0, 1);  step("R2");
    // R3 width cut
    clear_in(); set_b(0, 30, 4); set_t(0, 30, 1); step("R3");
    clear_in(); set_b(0, 30, 1); set_t(0, 30, 4); step("R3");
    clear_in(); set_b(0, 30, 3); set_t(0, 30, 3); step("R3");
    // R4 invalid ignored
    clear_in(); set_b(0, 40, 1); set_t(0, 40, 1); bot_vld = '0; step("R4");
    clear_in(); set_b(0, 40, 1); set_t(0, 40, 1); top_vld = '0; step("R4");
    // R5 first top wins
    clear_in(); set_b(0, 60, 1); set_t(1, 58, 1); set_t(3, 61, 1); set_t(0, 90, 1); step("R5");
    // R6 six matches, lowest four kept, in order
    clear_in();
    for (int i = 0; i < 6; i++) begin set_b(i, 10 + 20*i, 1); set_t(i, 11 + 20*i, 1); end
    step("R6");
    clear_in(); set_b(1, 100, 1); set_b(4, 150, 1); set_t(2, 99, 1); set_t(5, 152, 1); step("R6");
    // R7 R8 full suppression and count
    clear_in(); set_b(0, 70, 1); set_t(0, 70, 1); set_b(2, 80, 1); set_t(2, 81, 1);
    fifo_full = 1'b1; step("R7");
    fifo_full = 1'b0; step("R8");
    // R8 saturation with four stubs per cycle
    clear_in();
    for (int i = 0; i < 6; i++) begin set_b(i, 10 + 20*i, 1); set_t(i, 10 + 20*i, 1); end
    fifo_full = 1'b1;
    for (int c = 0; c < 20; c++) step("R8");
    fifo_full = 1'b0; step("R8");
    // random traffic
    cfg_omin = -9'sd2; cfg_omax = 9'sd5; cfg_wmax = 3'd4;
    for (int c = 0; c < 300; c++) begin
      clear_in();
      for (int i = 0; i < 6; i++) begin
        if ($urandom_range(0, 3) != 0) set_b(i, $urandom_range(0, 60), $urandom_range(0, 7));
        if ($urandom_range(0, 3) != 0) set_t(i, $urandom_range(0, 60), $urandom_range(0, 7));
      end
      fifo_full = ($urandom_range(0, 9) == 0);
      step("R2");
    end
    clear_in(); step("R1"); step("R1");
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule